// File: doc/BRIEF.md
# Framed Byte-Stream Packet Serializer

This block turns parallel transaction packets into a framed, most-significant-byte-first byte stream for a point-to-point chip link. It emits one byte per byte slot, together with a frame signal. A packet enters over a valid/wait handshake. The packet carries a write flag, an access flag, a 2-bit data mode, a 4-bit control mode, a 32-bit destination address, 64 bits of data and a 32-bit source address. The serializer sends a six-byte header and then one or two 32-bit words. The low word always goes first.

The far end pushes back on reads and on writes separately. Each of those two pushback inputs crosses a two-stage synchroniser before it can hold off new packets of its own type. A packet that has already started always runs to its last byte.

Consecutive 64-bit writes to addresses 8 apart are sent as a burst. The frame stays high, the header is skipped, and the next packet's data follows straight on. Every other pair of packets is separated by at least one slot with the frame low.

Top module: `lnk_pkt_serializer`

## Requirements
- R1: After reset, out_frame is 0, out_byte is 0, and in_wait is 0 while neither pushback input is high.
- R2: A new packet starts with byte index 0, which is 8'h00, in the same slot where out_frame rises. Header bytes 1 to 5 follow in this order:
  - byte 1 is {ctrlmode[3:0], dstaddr[31:28]};
  - bytes 2 to 4 are dstaddr[27:4], most significant byte first;
  - byte 5 is {dstaddr[3:0], datamode[1:0], write, access}.
- R3: A write whose data mode is not 2'b11 sends data[31:0] in bytes 6 to 9, most significant byte first. The frame drops after byte 9, so the packet is 10 bytes long.
- R4: A read (write flag 0) sends srcaddr[31:0] in bytes 6 to 9 in place of the data, most significant byte first, and also ends after byte 9.
- R5: A write with data mode 2'b11 (64-bit) sends data[31:0] in bytes 6 to 9 and then data[63:32] in bytes 10 to 13, each word most significant byte first. The packet is 14 bytes long.
- R6: A burst continuation needs all of the following:
  - a 64-bit write is offered during the final byte of a 64-bit write;
  - its destination is exactly 8 above the previous destination;
  - its control mode and data mode are equal to those of the previous packet.
  When these hold, the new packet is accepted in that slot, out_frame stays high, and the next slot carries byte 6 of the new packet with no header.
- R7: Any other packet offered at the end of a packet waits for out_frame to be low for at least one slot. It then begins with a full header.
- R8: in_wait is high while a packet is being sent, except in a slot that allows a burst continuation (R6). A packet is taken only on a clock edge where in_valid is 1 and in_wait is 0.
- R9: Each pushback input reaches in_wait on the second rising clock edge after it is set, not the first. The read pushback holds off only reads (in_write 0), and the write pushback holds off only writes (in_write 1).
- R10: A packet that is already being sent when its pushback goes high completes all of its bytes with the frame held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-slot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Packet offered |
| in_write | input | 1 | Write flag (0 = read) |
| in_access | input | 1 | Access flag, sent in header byte 5 |
| in_datamode | input | 2 | Data size code, 2'b11 = 64-bit |
| in_ctrlmode | input | 4 | Control mode, sent in header byte 1 |
| in_dstaddr | input | 32 | Destination address |
| in_data | input | 64 | Write data |
| in_srcaddr | input | 32 | Return address for reads |
| in_wait | output | 1 | Packet cannot be taken in this slot |
| far_rd_wait | input | 1 | Asynchronous read pushback from the far end |
| far_wr_wait | input | 1 | Asynchronous write pushback from the far end |
| out_byte | output | 8 | Byte of the current slot |
| out_frame | output | 1 | High while a packet's bytes are on out_byte |

## Verification
The bench chains three 64-bit writes 8 apart. A design that checked the stride wrongly, or that reinserted the header, would either drop the frame or send bytes 0 to 5 where byte 6 is due. It then chains writes with a stride of 16 and with a changed control mode. A design that bursts too eagerly would show no idle slot before those packets.

A read checks that the source address replaces the data. Pushback is sampled between the first and the second synchroniser edge, so a one-stage or three-stage path shows in_wait one slot early or late. Pushback is also raised in the middle of a 64-bit write, and a design that cut the packet short would leave expected bytes unsent.

// File: rtl/lnk_ser_pkg.sv
package lnk_ser_pkg;

   localparam int unsigned IDX_W     = 4;
   localparam int unsigned LAST_SHORT = 9;
   localparam int unsigned LAST_LONG  = 13;
   localparam int unsigned DATA_START = 6;

   localparam logic [1:0] DMODE_WIDE = 2'b11;

   typedef struct packed {
      logic        wr;
      logic        acc;
      logic [1:0]  dmode;
      logic [3:0]  cmode;
      logic [31:0] dst;
      logic [63:0] data;
      logic [31:0] src;
   } lnk_pkt_t;

   function automatic logic is_wide_write(input logic wr, input logic [1:0] dmode);
      return wr && (dmode == DMODE_WIDE);
   endfunction

endpackage

// File: rtl/lnk_wait_sync.sv
module lnk_wait_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("lnk_wait_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in};
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/lnk_byte_mux.sv
module lnk_byte_mux
   import lnk_ser_pkg::*;
(
   input  lnk_pkt_t         pkt,
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       byte_o
);

   logic [31:0] first_word;
   logic [31:0] second_word;

   always_comb begin
      first_word  = pkt.wr ? pkt.data[31:0] : pkt.src;
      second_word = pkt.data[63:32];
      case (idx)
         4'd0:    byte_o = 8'h00;
         4'd1:    byte_o = {pkt.cmode, pkt.dst[31:28]};
         4'd2:    byte_o = pkt.dst[27:20];
         4'd3:    byte_o = pkt.dst[19:12];
         4'd4:    byte_o = pkt.dst[11:4];
         4'd5:    byte_o = {pkt.dst[3:0], pkt.dmode, pkt.wr, pkt.acc};
         4'd6:    byte_o = first_word[31:24];
         4'd7:    byte_o = first_word[23:16];
         4'd8:    byte_o = first_word[15:8];
         4'd9:    byte_o = first_word[7:0];
         4'd10:   byte_o = second_word[31:24];
         4'd11:   byte_o = second_word[23:16];
         4'd12:   byte_o = second_word[15:8];
         4'd13:   byte_o = second_word[7:0];
         default: byte_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/lnk_burst_gate.sv
module lnk_burst_gate
   import lnk_ser_pkg::*;
#(
   parameter bit          ENABLE = 1'b1,
   parameter int unsigned STRIDE = 8
) (
   input  logic        cur_wide,
   input  logic [1:0]  cur_dmode,
   input  logic [3:0]  cur_cmode,
   input  logic [31:0] cur_dst,
   input  logic        nxt_wr,
   input  logic [1:0]  nxt_dmode,
   input  logic [3:0]  nxt_cmode,
   input  logic [31:0] nxt_dst,
   output logic        may_chain
);

   localparam logic [31:0] STEP = 32'(STRIDE);

   generate
      if (STRIDE == 0) begin : g_bad_stride
         $error("lnk_burst_gate: STRIDE must be non-zero");
      end
      if (ENABLE) begin : g_chain
         always_comb begin
            may_chain = cur_wide
                     && is_wide_write(nxt_wr, nxt_dmode)
                     && (cur_dmode == nxt_dmode)
                     && (cur_cmode == nxt_cmode)
                     && (nxt_dst == cur_dst + STEP);
         end
      end else begin : g_no_chain
         assign may_chain = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/lnk_pkt_serializer.sv
module lnk_pkt_serializer
   import lnk_ser_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          BURST_EN     = 1'b1,
   parameter int unsigned BURST_STRIDE = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_write,
   input  logic        in_access,
   input  logic [1:0]  in_datamode,
   input  logic [3:0]  in_ctrlmode,
   input  logic [31:0] in_dstaddr,
   input  logic [63:0] in_data,
   input  logic [31:0] in_srcaddr,
   output logic        in_wait,
   input  logic        far_rd_wait,
   input  logic        far_wr_wait,
   output logic [7:0]  out_byte,
   output logic        out_frame
);

   localparam logic [IDX_W-1:0] IDX_FIRST = '0;
   localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(DATA_START);
   localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(LAST_SHORT);
   localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(LAST_LONG);

   generate
      if ((1 << IDX_W) <= LAST_LONG) begin : g_bad_idx
         $error("lnk_pkt_serializer: index width too small");
      end
   endgenerate

   // Pushback synchronisers
   logic rd_hold, wr_hold;

   lnk_wait_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .async_in(far_rd_wait), .sync_out(rd_hold));

   lnk_wait_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .async_in(far_wr_wait), .sync_out(wr_hold));

   // Slot state
   lnk_pkt_t         pkt_q;
   logic             frame_q;
   logic [IDX_W-1:0] idx_q;

   lnk_pkt_t in_pkt;
   always_comb begin
      in_pkt.wr    = in_write;
      in_pkt.acc   = in_access;
      in_pkt.dmode = in_datamode;
      in_pkt.cmode = in_ctrlmode;
      in_pkt.dst   = in_dstaddr;
      in_pkt.data  = in_data;
      in_pkt.src   = in_srcaddr;
   end

   logic             cur_wide;
   logic [IDX_W-1:0] last_idx;
   logic             at_last;
   logic             may_chain;
   logic             slot_free;
   logic             type_hold;
   logic             take;

   assign cur_wide = is_wide_write(pkt_q.wr, pkt_q.dmode);
   assign last_idx = cur_wide ? IDX_LONG : IDX_SHORT;
   assign at_last  = frame_q && (idx_q == last_idx);

   lnk_burst_gate #(.ENABLE(BURST_EN), .STRIDE(BURST_STRIDE)) u_gate (
      .cur_wide (cur_wide),
      .cur_dmode(pkt_q.dmode),
      .cur_cmode(pkt_q.cmode),
      .cur_dst  (pkt_q.dst),
      .nxt_wr   (in_write),
      .nxt_dmode(in_datamode),
      .nxt_cmode(in_ctrlmode),
      .nxt_dst  (in_dstaddr),
      .may_chain(may_chain)
   );

   assign type_hold = in_write ? wr_hold : rd_hold;
   assign slot_free = !frame_q || (at_last && may_chain);
   assign in_wait   = !slot_free || type_hold;
   assign take      = in_valid && !in_wait;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_q   <= '0;
         frame_q <= 1'b0;
         idx_q   <= IDX_FIRST;
      end else if (take) begin
         pkt_q   <= in_pkt;
         frame_q <= 1'b1;
         idx_q   <= frame_q ? IDX_DATA : IDX_FIRST;
      end else if (at_last) begin
         frame_q <= 1'b0;
         idx_q   <= IDX_FIRST;
      end else if (frame_q) begin
         idx_q   <= idx_q + 1'b1;
      end
   end

   // Output byte
   logic [7:0] mux_byte;

   lnk_byte_mux u_mux (.pkt(pkt_q), .idx(idx_q), .byte_o(mux_byte));

   assign out_byte  = frame_q ? mux_byte : 8'h00;
   assign out_frame = frame_q;

   // Checks
   AST_HDR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_frame) |-> (out_byte == 8'h00 && idx_q == IDX_FIRST)) else $error("header"); // R2

   AST_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_frame && !at_last) |=> out_frame) else $error("cut"); // R10

   AST_GAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      (at_last && !take) |=> !out_frame) else $error("gap"); // R7

   AST_WR_HONOURS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_wait && in_write) |-> !wr_hold) else $error("wr hold"); // R9

   AST_RD_HONOURS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_wait && !in_write) |-> !rd_hold) else $error("rd hold"); // R9

   AST_CHAIN_WIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_frame && $past(out_frame) && idx_q == IDX_DATA && $past(idx_q) == IDX_LONG)
      |-> cur_wide) else $error("chain"); // R6

endmodule

// File: tb/lnk_pkt_serializer_tb_top.sv
`timescale 1ns/1ps
module lnk_pkt_serializer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_write = 1'b0;
   logic        in_access = 1'b0;
   logic [1:0]  in_datamode = 2'b00;
   logic [3:0]  in_ctrlmode = 4'h0;
   logic [31:0] in_dstaddr = '0;
   logic [63:0] in_data = '0;
   logic [31:0] in_srcaddr = '0;
   logic        in_wait;
   logic        far_rd_wait = 1'b0;
   logic        far_wr_wait = 1'b0;
   logic [7:0]  out_byte;
   logic        out_frame;

   always #4 clk = ~clk;

   lnk_pkt_serializer dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_write(in_write),
      .in_access(in_access), .in_datamode(in_datamode), .in_ctrlmode(in_ctrlmode),
      .in_dstaddr(in_dstaddr), .in_data(in_data), .in_srcaddr(in_srcaddr),
      .in_wait(in_wait), .far_rd_wait(far_rd_wait), .far_wr_wait(far_wr_wait),
      .out_byte(out_byte), .out_frame(out_frame));

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0] exp_byte_q[$];
   bit         exp_first_q[$];
   string      exp_tag_q[$];

   // chain tracking for the burst model
   bit          last_ok = 0;
   bit          last_wide = 0;
   logic [1:0]  last_dm = '0;
   logic [3:0]  last_cm = '0;
   logic [31:0] last_dst = '0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b, input bit first, input string tag);
      exp_byte_q.push_back(b);
      exp_first_q.push_back(first);
      exp_tag_q.push_back(tag);
   endtask

   task automatic send(input bit wr, input bit acc, input logic [1:0] dm, input logic [3:0] cm,
                       input logic [31:0] dst, input logic [63:0] data, input logic [31:0] src,
                       input bit chained, input string tag);
      bit          wide;
      bit          cont;
      logic [31:0] w0;
      wide = wr && (dm == 2'b11);
      cont = chained && last_ok && last_wide && wide && (dm == last_dm) && (cm == last_cm)
             && (dst == last_dst + 32'd8);
      w0 = wr ? data[31:0] : src;
      if (!cont) begin
         push(8'h00, 1'b1, tag);
         push({cm, dst[31:28]}, 1'b0, tag);
         push(dst[27:20], 1'b0, tag);
         push(dst[19:12], 1'b0, tag);
         push(dst[11:4], 1'b0, tag);
         push({dst[3:0], dm, wr, acc}, 1'b0, tag);
      end
      for (int k = 3; k >= 0; k--) push(w0[8*k +: 8], 1'b0, tag);
      if (wide) for (int k = 7; k >= 4; k--) push(data[8*k +: 8], 1'b0, tag);
      last_ok = 1; last_wide = wide; last_dm = dm; last_cm = cm; last_dst = dst;
      in_write = wr; in_access = acc; in_datamode = dm; in_ctrlmode = cm;
      in_dstaddr = dst; in_data = data; in_srcaddr = src; in_valid = 1'b1;
      #1;
      while (in_wait) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      last_ok = 0;
   endtask

   // Monitor: scoreboard compare of every framed byte
   bit prev_frame = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_frame) begin
            if (exp_byte_q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL stray byte actual=%0h expected=none", out_byte);
            end else begin
               automatic logic [7:0] eb = exp_byte_q.pop_front();
               automatic bit         ef = exp_first_q.pop_front();
               automatic string      et = exp_tag_q.pop_front();
               check({et, " byte"}, {56'd0, out_byte}, {56'd0, eb});
               check({et, " frame start"}, {63'd0, !prev_frame}, {63'd0, ef});
            end
         end
         prev_frame = out_frame;
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 frame", {63'd0, out_frame}, 64'd0);
      check("R1 byte", {56'd0, out_byte}, 64'd0);
      check("R1 wait", {63'd0, in_wait}, 64'd0);

      // R2 R3 short write
      send(1, 1, 2'b10, 4'h5, 32'h8123_4567, 64'hDEAD_BEEF_0A1B_2C3D, 32'h0, 0, "R2/R3 write32");
      // R8: busy mid-packet
      @(negedge clk); #1;
      check("R8 busy wait", {63'd0, in_wait}, 64'd1);
      idle(20);

      // R4 read carries source address
      send(0, 1, 2'b10, 4'h3, 32'h0ABC_DEF0, 64'h1111_2222_3333_4444, 32'h9876_5432, 0, "R4 read");
      idle(20);

      // R5 wide write
      send(1, 0, 2'b11, 4'hA, 32'h4000_0010, 64'hA1A2_A3A4_B1B2_B3B4, 32'h0, 0, "R5 write64");
      idle(20);

      // R6 burst chain of three
      send(1, 1, 2'b11, 4'h2, 32'h2000_0100, 64'h0102_0304_0506_0708, 32'h0, 0, "R6 burst head");
      send(1, 1, 2'b11, 4'h2, 32'h2000_0108, 64'h1112_1314_1516_1718, 32'h0, 1, "R6 burst 2");
      send(1, 1, 2'b11, 4'h2, 32'h2000_0110, 64'h2122_2324_2526_2728, 32'h0, 1, "R6 burst 3");
      // R7 stride 16: not eligible
      send(1, 1, 2'b11, 4'h2, 32'h2000_0120, 64'h3132_3334_3536_3738, 32'h0, 1, "R7 stride");
      // R7 control mode change: not eligible
      send(1, 1, 2'b11, 4'h6, 32'h2000_0128, 64'h4142_4344_4546_4748, 32'h0, 1, "R7 ctrl");
      // R7 short write after wide
      send(1, 1, 2'b10, 4'h6, 32'h2000_0130, 64'h0, 32'h0, 1, "R7 short");
      idle(20);

      // R9 synchroniser lag for read pushback
      in_write = 1'b0;
      far_rd_wait = 1'b1;
      @(negedge clk); #1;
      check("R9 one edge", {63'd0, in_wait}, 64'd0);
      @(negedge clk); #1;
      check("R9 two edges", {63'd0, in_wait}, 64'd1);
      in_write = 1'b1; #1;
      check("R9 write unaffected", {63'd0, in_wait}, 64'd0);
      far_rd_wait = 1'b0;
      idle(4);

      // R10 pushback mid-packet
      send(1, 1, 2'b11, 4'h1, 32'h7000_0000, 64'hC1C2_C3C4_D1D2_D3D4, 32'h0, 0, "R10 in flight");
      repeat (3) @(negedge clk);
      far_wr_wait = 1'b1;
      idle(20);
      in_write = 1'b1; #1;
      check("R9 write held", {63'd0, in_wait}, 64'd1);
      send(0, 0, 2'b10, 4'h0, 32'h0000_1230, 64'h0, 32'hCAFE_F00D, 0, "R9 read passes");
      idle(20);
      far_wr_wait = 1'b0;
      idle(3);
      in_write = 1'b1; #1;
      check("R9 write released", {63'd0, in_wait}, 64'd0);

      check("R3 all bytes sent", 64'(exp_byte_q.size()), 64'd0);
      finish_run();
   end

endmodule